// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Cycle Controller

This block is the cycle decoder of a pipelined synchronous SRAM that has no bus turnaround penalty. On every rising clock edge it samples three chip selects, a load/advance input, a write input, per-byte lane selects, a stall request and a sleep request. From these it decides whether the edge starts a new access, continues the burst in progress, deselects, is ignored, or belongs to the sleep sequence. It then drives read and write strobes with a byte mask into a small internal byte-lane memory. The read data is registered and shows up on the data output one cycle after its address. Tri-state control of the data bus is modelled as a drive-enable output. The output enable acts on that drive-enable without a clock and is masked whenever the last decoded cycle was not a read.

Bursts are four beats long and wrap. A two-bit beat counter runs over the low address bits, either in linear order (add the count) or in interleaved order (XOR the count). The order is chosen by a strap sampled when each burst begins. The cycle state machine has these states: `CS_DESEL` (idle/deselected), `CS_READ` and `CS_WRITE` (burst in progress), `CS_ZZ_IN1` and `CS_ZZ_IN2` (sleep entry), `CS_ZZ` (asleep), and `CS_WAKE1` and `CS_WAKE2` (recovery). Its transitions are as follows:
- A load edge with selects valid goes to `CS_READ` or `CS_WRITE`, depending on the write input.
- A load edge with any select invalid goes to `CS_DESEL`.
- An advance edge or a stalled edge keeps the current state.
- A sleep request in any normal state goes to `CS_ZZ_IN1`.
- `CS_ZZ_IN1` steps to `CS_ZZ_IN2`, and `CS_ZZ_IN2` steps to `CS_ZZ`.
- `CS_ZZ` goes to `CS_WAKE1` once sleep is sampled low.
- `CS_WAKE1` steps to `CS_WAKE2`, and `CS_WAKE2` steps to `CS_DESEL`.

Top module: `ssram_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is deselected and `bus_drive` is 0 whatever `out_en_n` is.
- R2: A load edge (`load_n`=0) is a deselect when `sel0_n`=1 or `sel1`=0 or `sel2_n`=1. After it, `bus_drive` is 0 and no array access happens. Later advance edges (`load_n`=1) stay deselected.
- R3: A load edge with valid selects and `wr_n`=1 reads the word at `addr`. In the following cycle `rdata` carries that word while `out_en_n` is 0.
- R4: Each advance edge of a burst moves a 2-bit beat count c (0 at load, wrapping mod 4). The address is {base[5:2], base[1:0]+c} when `interleave` was 0 at load, and {base[5:2], base[1:0]^c} when it was 1.
- R5: A read with `out_en_n`=1 leaves the bus undriven but still advances the burst, so later beats return the correct words.
- R6: A write edge stores byte lane i (`wdata[8i+7:8i]`) only where `lane_n[i]`=0. Advance edges of a write burst write at the next burst address and ignore `wr_n`.
- R7: A write edge with every `lane_n` bit 1 (an abort) changes no memory byte, but an advance still steps the burst address.
- R8: In the cycle after any write or abort edge, `bus_drive` is 0 even with `out_en_n`=0.
- R9: `out_en_n` acts without a clock: after a read edge, `bus_drive` follows its inverse within the same cycle.
- R10: An edge with `stall_req`=1 (and no sleep) changes nothing: state, burst position, memory and outputs are kept.
- R11: An edge with `sleep_req`=1 enters sleep, drops any burst and tri-states the bus from the next cycle. All other inputs are ignored until recovery ends.
- R12: After the edge that samples `sleep_req` low while asleep, the next two edges are still ignored. The third edge is decoded from the deselected state.
- R13: `arr_rd` is 1 on edges that perform a read (including a dummy read). `arr_be` equals ~`lane_n` on write edges and 0 otherwise. `arr_wr` is 1 only when `arr_be` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| load_n | input | 1 | 0 = start new cycle from `addr`, 1 = advance burst |
| wr_n | input | 1 | 0 = write, 1 = read (sampled on load edges) |
| lane_n | input | LANES | Per-byte write selects, active low |
| stall_req | input | 1 | 1 = ignore this clock edge |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| sleep_req | input | 1 | 1 = request sleep |
| interleave | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address for load edges |
| wdata | input | LANES*8 | Write data |
| rdata | output | LANES*8 | Read data, zero when not driven |
| bus_drive | output | 1 | Data bus drive enable (0 = tri-state) |
| arr_rd | output | 1 | Array read strobe for this edge |
| arr_wr | output | 1 | Array write strobe for this edge |
| arr_be | output | LANES | Array byte mask for this edge |

## Verification
The unclocked output enable and the registered read pipeline meet in the same cycle. In the cycle after a read edge, `out_en_n` is toggled between edges, and `bus_drive`/`rdata` are sampled after each change. They must follow at once, without waiting for an edge. A stall and a burst in progress also coincide: stalled edges land in the middle of a read burst with conflicting load and write inputs. After the stall, the next advance must return the beat the reference model predicts, and no byte written during the stall may appear later.

// File: rtl/ssram_ctrl_pkg.sv
package ssram_ctrl_pkg;

    typedef enum logic [2:0] {
        CS_DESEL  = 3'd0,
        CS_READ   = 3'd1,
        CS_WRITE  = 3'd2,
        CS_ZZ_IN1 = 3'd3,
        CS_ZZ_IN2 = 3'd4,
        CS_ZZ     = 3'd5,
        CS_WAKE1  = 3'd6,
        CS_WAKE2  = 3'd7
    } cyc_state_e;

    localparam int BEAT_W = 2;

endpackage

// File: rtl/ssram_cycle_fsm.sv
module ssram_cycle_fsm
    import ssram_ctrl_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic             sel2_n,
    input  logic             load_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             stall_req,
    input  logic             sleep_req,
    output cyc_state_e       state,
    output logic             live,
    output logic             hold,
    output logic             do_load,
    output logic             do_adv,
    output logic             arr_rd,
    output logic             arr_wr,
    output logic [LANES-1:0] arr_be
);

    cyc_state_e nxt;
    logic       chosen;
    logic       normal;
    logic       read_kind;
    logic       access;

    assign chosen = !sel0_n && sel1 && !sel2_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CS_DESEL;
        end else begin
            state <= nxt;
        end
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            CS_DESEL, CS_READ, CS_WRITE: begin
                if (sleep_req) begin
                    nxt = CS_ZZ_IN1;
                end else if (!stall_req && !load_n) begin
                    if (!chosen) begin
                        nxt = CS_DESEL;
                    end else if (wr_n) begin
                        nxt = CS_READ;
                    end else begin
                        nxt = CS_WRITE;
                    end
                end
            end
            CS_ZZ_IN1: nxt = CS_ZZ_IN2;
            CS_ZZ_IN2: nxt = CS_ZZ;
            CS_ZZ:     nxt = sleep_req ? CS_ZZ : CS_WAKE1;
            CS_WAKE1:  nxt = CS_WAKE2;
            CS_WAKE2:  nxt = CS_DESEL;
            default:   nxt = CS_DESEL;
        endcase
    end

    // output decode
    always_comb begin
        normal    = (state == CS_DESEL) || (state == CS_READ) || (state == CS_WRITE);
        live      = normal && !sleep_req && !stall_req;
        hold      = normal && !sleep_req && stall_req;
        do_load   = live && !load_n && chosen;
        do_adv    = live && load_n && ((state == CS_READ) || (state == CS_WRITE));
        access    = do_load || do_adv;
        read_kind = do_load ? wr_n : (state == CS_READ);
        arr_rd    = access && read_kind;
        arr_be    = (access && !read_kind) ? ~lane_n : '0;
        arr_wr    = |arr_be;
    end

endmodule

// File: rtl/ssram_burst_seq.sv
module ssram_burst_seq
    import ssram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] next_addr
);

    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] cnt;
    logic              il;
    logic [BEAT_W-1:0] nxt_cnt;
    logic [BEAT_W-1:0] low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0;
            cnt  <= '0;
            il   <= 1'b0;
        end else if (load) begin
            base <= addr_in;
            cnt  <= '0;
            il   <= interleave;
        end else if (adv) begin
            cnt  <= nxt_cnt;
        end
    end

    always_comb begin
        nxt_cnt   = cnt + BEAT_ONE;
        low       = il ? (base[BEAT_W-1:0] ^ nxt_cnt) : (base[BEAT_W-1:0] + nxt_cnt);
        next_addr = {base[ADDR_W-1:BEAT_W], low};
    end

endmodule

// File: rtl/ssram_lane_array.sv
module ssram_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rd_en,
    input  logic [LANES-1:0]        be,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata_q
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (be[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (rd_en) begin
                q <= mem[addr];
            end
        end

        assign rdata_q[g*LANE_W +: LANE_W] = q;
    end

endmodule

// File: rtl/ssram_cycle_ctrl.sv
module ssram_cycle_ctrl
    import ssram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    load_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    stall_req,
    input  logic                    out_en_n,
    input  logic                    sleep_req,
    input  logic                    interleave,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    bus_drive,
    output logic                    arr_rd,
    output logic                    arr_wr,
    output logic [LANES-1:0]        arr_be
);

    localparam int DATA_W = LANES * LANE_W;

    cyc_state_e        fsm_state;
    logic              live;
    logic              hold;
    logic              do_load;
    logic              do_adv;
    logic [ADDR_W-1:0] seq_next;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] arr_q;
    logic              q_valid;

    ssram_cycle_fsm #(.LANES(LANES)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel0_n    (sel0_n),
        .sel1      (sel1),
        .sel2_n    (sel2_n),
        .load_n    (load_n),
        .wr_n      (wr_n),
        .lane_n    (lane_n),
        .stall_req (stall_req),
        .sleep_req (sleep_req),
        .state     (fsm_state),
        .live      (live),
        .hold      (hold),
        .do_load   (do_load),
        .do_adv    (do_adv),
        .arr_rd    (arr_rd),
        .arr_wr    (arr_wr),
        .arr_be    (arr_be)
    );

    ssram_burst_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (do_load),
        .adv        (do_adv),
        .interleave (interleave),
        .addr_in    (addr),
        .next_addr  (seq_next)
    );

    assign cur_addr = do_load ? addr : seq_next;

    ssram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_arr (
        .clk     (clk),
        .rd_en   (arr_rd),
        .be      (arr_be),
        .addr    (cur_addr),
        .wdata   (wdata),
        .rdata_q (arr_q)
    );

    // marks that the last decoded edge was a read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
        end else if (live) begin
            q_valid <= arr_rd;
        end else if (!hold) begin
            q_valid <= 1'b0;
        end
    end

    assign bus_drive = q_valid && !out_en_n;
    assign rdata     = bus_drive ? arr_q : '0;

endmodule

// File: rtl/ssram_cycle_ctrl_chk.sv
module ssram_cycle_ctrl_chk
    import ssram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_req,
    input logic              stall_req,
    input logic              out_en_n,
    input logic              bus_drive,
    input logic              arr_rd,
    input logic              arr_wr,
    input logic [LANES-1:0]  arr_be,
    input cyc_state_e        state,
    input logic              q_valid,
    input logic [ADDR_W-1:0] seq_next
);

    logic normal;
    assign normal = (state == CS_DESEL) || (state == CS_READ) || (state == CS_WRITE);

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!bus_drive);
        end
    end

    a_r3_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd |=> (bus_drive == !out_en_n));

    a_r8_write_masks_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_be != '0) |=> !bus_drive);

    a_r10_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_req && !sleep_req && normal) |=> ($stable(state) && $stable(seq_next) && $stable(q_valid)));

    a_r11_sleep_no_ops: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (!arr_rd && !arr_wr));

    a_r11_sleep_tri: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !bus_drive);

    a_r12_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CS_WAKE1) || (state == CS_WAKE2)) |-> (!arr_rd && !arr_wr));

    a_r12_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_WAKE2) |=> (state == CS_DESEL));

    a_r13_rd_wr_apart: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd |-> (arr_be == '0));

endmodule

bind ssram_cycle_ctrl ssram_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .stall_req (stall_req),
    .out_en_n  (out_en_n),
    .bus_drive (bus_drive),
    .arr_rd    (arr_rd),
    .arr_wr    (arr_wr),
    .arr_be    (arr_be),
    .state     (fsm_state),
    .q_valid   (q_valid),
    .seq_next  (seq_next)
);

// File: tb/test_ssram_cycle_ctrl.sv
module test_ssram_cycle_ctrl;

    localparam int AW = 6;
    localparam int LN = 2;
    localparam int LW = 8;
    localparam int DW = LN * LW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          sel0_n, sel1, sel2_n, load_n, wr_n;
    logic [LN-1:0] lane_n;
    logic          stall_req, out_en_n, sleep_req, interleave;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          bus_drive, arr_rd, arr_wr;
    logic [LN-1:0] arr_be;

    ssram_cycle_ctrl #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_ssram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .load_n(load_n), .wr_n(wr_n), .lane_n(lane_n), .stall_req(stall_req),
        .out_en_n(out_en_n), .sleep_req(sleep_req), .interleave(interleave),
        .addr(addr), .wdata(wdata), .rdata(rdata), .bus_drive(bus_drive),
        .arr_rd(arr_rd), .arr_wr(arr_wr), .arr_be(arr_be)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference
    logic [DW-1:0] mem_m [1<<AW];
    int            st_m = 0;   // 0 idle, 1 read burst, 2 write burst
    int            zz_m = 0;   // 0 awake, 1..3 entering/asleep, 4..5 recovering
    logic [AW-1:0] base_m = '0;
    logic [1:0]    cnt_m = '0;
    bit            il_m = 1'b0;
    bit            v_m = 1'b0;
    logic [DW-1:0] q_m = '0;

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 16'h0B1D + 16'h4C3A);
    endfunction

    task automatic chk(string req, logic [DW:0] act, logic [DW:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmp_bus();
        logic e;
        e = v_m && !out_en_n;
        chk(cur_req, {bus_drive, rdata}, {e, (e ? q_m : {DW{1'b0}})});
    endtask

    task automatic model();
        logic [AW-1:0] a;
        bit sel, beg, cont;
        sel = !sel0_n && sel1 && !sel2_n;
        if (!rst_n) begin
            st_m = 0; zz_m = 0; v_m = 1'b0;
        end else if (zz_m != 0) begin
            case (zz_m)
                1: zz_m = 2;
                2: zz_m = 3;
                3: if (!sleep_req) zz_m = 4;
                4: zz_m = 5;
                default: begin zz_m = 0; st_m = 0; end
            endcase
        end else if (sleep_req) begin
            zz_m = 1; v_m = 1'b0; st_m = 0;
        end else if (!stall_req) begin
            beg  = !load_n && sel;
            cont = load_n && (st_m != 0);
            if (!load_n && !sel) begin
                st_m = 0; v_m = 1'b0;
            end else if (beg || cont) begin
                if (beg) begin
                    base_m = addr; cnt_m = 2'd0; il_m = interleave; a = addr;
                    st_m = wr_n ? 1 : 2;
                end else begin
                    cnt_m = cnt_m + 2'd1;
                    a = {base_m[AW-1:2], (il_m ? (base_m[1:0] ^ cnt_m) : (base_m[1:0] + cnt_m))};
                end
                if (st_m == 1) begin
                    q_m = mem_m[a]; v_m = 1'b1;
                end else begin
                    for (int i = 0; i < LN; i++)
                        if (!lane_n[i]) mem_m[a][i*LW +: LW] = wdata[i*LW +: LW];
                    v_m = 1'b0;
                end
            end else begin
                v_m = 1'b0;
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model();
        #2;
        cmp_bus();
    endtask

    task automatic beg_rd(logic [AW-1:0] a);
        sel0_n = 0; sel1 = 1; sel2_n = 0; load_n = 0; wr_n = 1; lane_n = '1; addr = a;
        tick();
    endtask

    task automatic beg_wr(logic [AW-1:0] a, logic [LN-1:0] ln, logic [DW-1:0] wd);
        sel0_n = 0; sel1 = 1; sel2_n = 0; load_n = 0; wr_n = 0; lane_n = ln; addr = a; wdata = wd;
        tick();
    endtask

    task automatic cont_c(logic wn, logic [LN-1:0] ln, logic [DW-1:0] wd);
        load_n = 1; wr_n = wn; lane_n = ln; wdata = wd; addr = ~addr; sel0_n = 1;
        tick();
    endtask

    task automatic desel(logic s0n, logic s1, logic s2n);
        sel0_n = s0n; sel1 = s1; sel2_n = s2n; load_n = 0; wr_n = 1; lane_n = '1;
        tick();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;
        rst_n = 0; sel0_n = 1; sel1 = 1; sel2_n = 0; load_n = 0; wr_n = 1; lane_n = '1;
        stall_req = 0; out_en_n = 0; sleep_req = 0; interleave = 0; addr = '0; wdata = '0;

        // R1: reset with output enable asserted
        cur_req = "R1";
        tick(); tick(); tick();
        rst_n = 1;
        tick();

        // R6: fill the array with linear write bursts
        cur_req = "R6";
        for (int b = 0; b < 16; b++) begin
            beg_wr(AW'(b * 4), 2'b00, pat(b * 4));
            for (int k = 1; k < 4; k++) cont_c(1'b0, 2'b00, pat(b * 4 + k));
        end

        // R3: single reads, data one cycle later
        cur_req = "R3";
        beg_rd(6'd9);
        beg_rd(6'd40);
        desel(1, 1, 0);

        // R4: linear wrap from an unaligned base, then interleaved
        cur_req = "R4";
        beg_rd(6'h0D);
        for (int k = 0; k < 4; k++) cont_c(1'b0, 2'b00, 16'hFFFF);
        interleave = 1;
        beg_rd(6'h16);
        for (int k = 0; k < 3; k++) cont_c(1'b1, 2'b11, '0);
        beg_rd(6'h23);
        for (int k = 0; k < 3; k++) cont_c(1'b1, 2'b11, '0);
        interleave = 0;

        // R5: dummy read advances the burst
        cur_req = "R5";
        out_en_n = 1;
        beg_rd(6'h31);
        cont_c(1'b1, 2'b11, '0);
        out_en_n = 0;
        cont_c(1'b1, 2'b11, '0);
        cont_c(1'b1, 2'b11, '0);

        // R6: byte lanes and ignored write input on continue
        cur_req = "R6";
        beg_wr(6'h05, 2'b10, 16'hAAAA);
        cont_c(1'b1, 2'b01, 16'hBBBB);
        cont_c(1'b0, 2'b00, 16'hCCCC);
        beg_rd(6'h05);
        cont_c(1'b1, 2'b11, '0);
        cont_c(1'b1, 2'b11, '0);

        // R7: abort on begin and on continue, then a real beat
        cur_req = "R7";
        beg_wr(6'h20, 2'b11, 16'hDEAD);
        cont_c(1'b0, 2'b11, 16'hBEEF);
        cont_c(1'b0, 2'b00, 16'h1234);
        beg_rd(6'h20);
        cont_c(1'b1, 2'b11, '0);
        cont_c(1'b1, 2'b11, '0);

        // R8: write between reads masks the bus
        cur_req = "R8";
        beg_rd(6'h10);
        beg_wr(6'h10, 2'b00, 16'h5A5A);
        beg_rd(6'h10);

        // R9: unclocked output enable
        cur_req = "R9";
        beg_rd(6'h11);
        out_en_n = 1; #1; cmp_bus();
        out_en_n = 0; #1; cmp_bus();
        out_en_n = 1; #1; cmp_bus();
        out_en_n = 0;

        // R10: stall inside a read burst with hostile inputs
        cur_req = "R10";
        beg_rd(6'h18);
        stall_req = 1;
        for (int k = 0; k < 3; k++) begin
            sel0_n = 0; sel1 = 1; sel2_n = 0; load_n = 0; wr_n = 0; lane_n = 2'b00;
            addr = AW'(6'h18 + k); wdata = 16'h0F0F;
            tick();
        end
        stall_req = 0;
        cont_c(1'b1, 2'b11, '0);
        cont_c(1'b1, 2'b11, '0);
        beg_rd(6'h18);
        cont_c(1'b1, 2'b11, '0);

        // R2: each select invalid, then advance edges while deselected
        cur_req = "R2";
        beg_rd(6'h01);
        desel(1, 1, 0);
        beg_rd(6'h02);
        desel(0, 0, 0);
        beg_rd(6'h03);
        desel(0, 1, 1);
        cont_c(1'b0, 2'b00, 16'h7777);
        cont_c(1'b1, 2'b11, '0);
        beg_rd(6'h03);

        // R11: sleep during a read burst, junk writes ignored
        cur_req = "R11";
        beg_rd(6'h2A);
        sleep_req = 1;
        for (int k = 0; k < 4; k++) begin
            sel0_n = 0; sel1 = 1; sel2_n = 0; load_n = 0; wr_n = 0; lane_n = 2'b00;
            addr = 6'h2A; wdata = 16'h9999;
            tick();
        end

        // R12: two ignored edges after wake, then resume deselected
        cur_req = "R12";
        sleep_req = 0;
        for (int k = 0; k < 3; k++) begin
            sel0_n = 0; sel1 = 1; sel2_n = 0; load_n = 0; wr_n = 0; lane_n = 2'b00;
            addr = 6'h2B; wdata = 16'h8888;
            tick();
        end
        cont_c(1'b1, 2'b11, '0);
        beg_rd(6'h2A);
        beg_rd(6'h2B);

        // R13: strobes and byte mask
        cur_req = "R13";
        sel0_n = 0; sel1 = 1; sel2_n = 0; load_n = 0; wr_n = 0; lane_n = 2'b10; addr = 6'h3F; wdata = 16'h4242;
        #1; chk("R13", {arr_rd, arr_wr, arr_be}, {1'b0, 1'b1, 2'b01});
        tick();
        lane_n = 2'b11;
        #1; chk("R13", {arr_rd, arr_wr, arr_be}, {1'b0, 1'b0, 2'b00});
        tick();
        wr_n = 1; lane_n = 2'b00;
        #1; chk("R13", {arr_rd, arr_wr, arr_be}, {1'b1, 1'b0, 2'b00});
        tick();
        beg_rd(6'h3F);
        tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule